// File: doc/BRIEF.md
# Instruction Cache Next-Line and Way Predictor

This block sits beside an instruction cache and supplies the fetch location for the next cycle without waiting for the full direction predictor. Each cache line, identified by its set index and way, owns a small pointer entry that names the set and way to fetch after it. The entry for the line currently being fetched is read combinationally, so the next fetch location is known by the end of the cycle and is registered into the fetch pointer at the clock edge.

Entries are seeded when a line is filled. The seed points to the next sequential set in way 0. Branch resolution later overwrites the entry of the line that held the branch with the real successor. When the quick guess turns out wrong, either at resolution or because a slower, more accurate predictor disagrees, a redirect input loads the correct location. The fetch outputs then carry one invalid cycle, which is the fixed cost of a wrong guess. A saturating counter records how many redirects have occurred.

Top module: `line_way_predictor`

## Requirements
- R1: While and after reset, until the first active clock edge with fetch enabled or a redirect, fetch_vld_o is 0, the fetch location is set 0 / way 0 and miss_count_o is 0. Every entry for set s (any way) predicts set (s+1) mod SETS, way 0.
- R2: pred_set_o and pred_way_o always show, in the same cycle, the stored entry of the line named by fetch_set_o and fetch_way_o.
- R3: In a cycle with fetch_vld_o=1, fetch_en_i=1 and redirect_i=0, the fetch location in the next cycle equals pred_set_o / pred_way_o of this cycle, and fetch_vld_o stays 1.
- R4: A fill of line (set f, way w) makes that line's entry predict set (f+1) mod SETS, way 0, from the next cycle on.
- R5: A resolution update of line (s, w) makes its entry predict upd_next_set_i / upd_next_way_i from the next cycle on.
- R6: When a fill and an update address the same entry in one cycle, the entry takes the fill value. When they address different entries, both are written.
- R7: A redirect in cycle t, whatever fetch_en_i is, puts the redirect target on the fetch outputs in cycle t+1 with fetch_vld_o=0. The next cycle with fetch_en_i=1 and no redirect keeps that location and raises fetch_vld_o, so a wrong guess costs exactly one fetch cycle.
- R8: With fetch_en_i=0 and no redirect, fetch location and fetch_vld_o hold. Fills and updates are still written.
- R9: miss_count_o (CNTW bits) increases by one in the cycle after each redirect cycle, saturates at all ones, and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fetch_en_i | input | 1 | Advance the fetch pointer this cycle |
| redirect_i | input | 1 | Wrong next-line guess; load the target below |
| redirect_set_i | input | IDXW | Correct set to fetch |
| redirect_way_i | input | WAYW | Correct way to fetch |
| fill_i | input | 1 | A line is being filled |
| fill_set_i | input | IDXW | Set of the filled line |
| fill_way_i | input | WAYW | Way of the filled line |
| upd_i | input | 1 | Branch resolution update |
| upd_set_i | input | IDXW | Set of the line holding the resolved branch |
| upd_way_i | input | WAYW | Way of that line |
| upd_next_set_i | input | IDXW | Actual successor set |
| upd_next_way_i | input | WAYW | Actual successor way |
| fetch_vld_o | output | 1 | Fetch location is valid (low during the bubble) |
| fetch_set_o | output | IDXW | Current fetch set |
| fetch_way_o | output | WAYW | Current fetch way |
| pred_set_o | output | IDXW | Predicted next set read from the current line |
| pred_way_o | output | WAYW | Predicted next way read from the current line |
| miss_count_o | output | CNTW | Saturating count of redirects |

## Verification
The assertions assume that every set and way index presented on the redirect, fill and update inputs lies within SETS and WAYS. With the default power-of-two sizes every code is legal, and the stimulus draws indices only from those ranges. The properties on fill and update contents also assume that the written entry becomes observable only when a redirect in the same cycle targets it. The stimulus uses exactly that pattern in its directed cases, while its random phase mixes fills, updates and redirects freely and leaves the stored contents to the cycle reference model.

// File: rtl/lwp_pkg.sv
package lwp_pkg;
  localparam int LWP_SETS_DEF = 16;
  localparam int LWP_WAYS_DEF = 2;
  localparam int LWP_CNTW_DEF = 8;

  // Source chosen for the next fetch pointer value
  typedef enum logic [1:0] {
    PTR_HOLD     = 2'd0,
    PTR_FOLLOW   = 2'd1,
    PTR_REDIRECT = 2'd2
  } ptr_src_e;
endpackage

// File: rtl/lwp_table.sv
module lwp_table #(
  parameter int SETS = 16,
  parameter int WAYS = 2,
  parameter int IDXW = $clog2(SETS),
  parameter int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_i,
  input  logic [IDXW-1:0] fill_set_i,
  input  logic [WAYW-1:0] fill_way_i,
  input  logic            upd_i,
  input  logic [IDXW-1:0] upd_set_i,
  input  logic [WAYW-1:0] upd_way_i,
  input  logic [IDXW-1:0] upd_next_set_i,
  input  logic [WAYW-1:0] upd_next_way_i,
  input  logic [IDXW-1:0] rd_set_i,
  input  logic [WAYW-1:0] rd_way_i,
  output logic [IDXW-1:0] rd_next_set_o,
  output logic [WAYW-1:0] rd_next_way_o
);
  localparam logic [IDXW-1:0] LAST_SET = IDXW'(SETS - 1);

  logic [IDXW-1:0] nset_q [SETS][WAYS];
  logic [WAYW-1:0] nway_q [SETS][WAYS];
  logic [IDXW-1:0] nset_d [SETS][WAYS];
  logic [WAYW-1:0] nway_d [SETS][WAYS];
  logic            wen    [SETS][WAYS];
  logic [IDXW-1:0] seq_set;

  // Sequential successor used to seed a filled line
  always_comb begin
    if (fill_set_i == LAST_SET) seq_set = '0;
    else                        seq_set = fill_set_i + 1'b1;
  end

  // Per-entry next-state: fill overrides a same-entry update
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        wen[s][w]    = 1'b0;
        nset_d[s][w] = nset_q[s][w];
        nway_d[s][w] = nway_q[s][w];
        if (upd_i && (upd_set_i == IDXW'(s)) && (upd_way_i == WAYW'(w))) begin
          wen[s][w]    = 1'b1;
          nset_d[s][w] = upd_next_set_i;
          nway_d[s][w] = upd_next_way_i;
        end
        if (fill_i && (fill_set_i == IDXW'(s)) && (fill_way_i == WAYW'(w))) begin
          wen[s][w]    = 1'b1;
          nset_d[s][w] = seq_set;
          nway_d[s][w] = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          nset_q[s][w] <= IDXW'((s + 1) % SETS);
          nway_q[s][w] <= '0;
        end
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (wen[s][w]) begin
            nset_q[s][w] <= nset_d[s][w];
            nway_q[s][w] <= nway_d[s][w];
          end
        end
      end
    end
  end

  // Read of the line being fetched, same cycle
  assign rd_next_set_o = nset_q[rd_set_i][rd_way_i];
  assign rd_next_way_o = nway_q[rd_set_i][rd_way_i];
endmodule

// File: rtl/lwp_fetch_ptr.sv
module lwp_fetch_ptr
  import lwp_pkg::*;
#(
  parameter int IDXW = 4,
  parameter int WAYW = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            redirect_i,
  input  logic [IDXW-1:0] tgt_set_i,
  input  logic [WAYW-1:0] tgt_way_i,
  input  logic [IDXW-1:0] pred_set_i,
  input  logic [WAYW-1:0] pred_way_i,
  output logic            vld_o,
  output logic [IDXW-1:0] set_o,
  output logic [WAYW-1:0] way_o
);
  ptr_src_e        src;
  logic            ptr_en;
  logic            vld_en;
  logic            vld_d, vld_q;
  logic [IDXW-1:0] set_d, set_q;
  logic [WAYW-1:0] way_d, way_q;

  always_comb begin
    src = PTR_HOLD;
    if (redirect_i)           src = PTR_REDIRECT;
    else if (en_i && vld_q)   src = PTR_FOLLOW;
  end

  always_comb begin
    set_d  = set_q;
    way_d  = way_q;
    vld_d  = vld_q;
    ptr_en = 1'b0;
    vld_en = 1'b0;
    unique case (src)
      PTR_REDIRECT: begin
        set_d  = tgt_set_i;
        way_d  = tgt_way_i;
        vld_d  = 1'b0;
        ptr_en = 1'b1;
        vld_en = 1'b1;
      end
      PTR_FOLLOW: begin
        set_d  = pred_set_i;
        way_d  = pred_way_i;
        ptr_en = 1'b1;
      end
      default: begin
        // Bubble or post-reset: leave the location, validate it
        if (en_i) begin
          vld_d  = 1'b1;
          vld_en = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '0;
      way_q <= '0;
    end else if (ptr_en) begin
      set_q <= set_d;
      way_q <= way_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= 1'b0;
    else if (vld_en) vld_q <= vld_d;
  end

  assign vld_o = vld_q;
  assign set_o = set_q;
  assign way_o = way_q;
endmodule

// File: rtl/lwp_miss_counter.sv
module lwp_miss_counter #(
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit_i,
  output logic [CNTW-1:0] count_o
);
  localparam logic [CNTW-1:0] CMAX = '1;

  logic [CNTW-1:0] cnt_d, cnt_q;
  logic            cnt_en;

  always_comb begin
    cnt_en = hit_i && (cnt_q != CMAX);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/line_way_predictor.sv
module line_way_predictor
  import lwp_pkg::*;
#(
  parameter int SETS = LWP_SETS_DEF,
  parameter int WAYS = LWP_WAYS_DEF,
  parameter int CNTW = LWP_CNTW_DEF,
  localparam int IDXW = $clog2(SETS),
  localparam int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_en_i,
  input  logic            redirect_i,
  input  logic [IDXW-1:0] redirect_set_i,
  input  logic [WAYW-1:0] redirect_way_i,
  input  logic            fill_i,
  input  logic [IDXW-1:0] fill_set_i,
  input  logic [WAYW-1:0] fill_way_i,
  input  logic            upd_i,
  input  logic [IDXW-1:0] upd_set_i,
  input  logic [WAYW-1:0] upd_way_i,
  input  logic [IDXW-1:0] upd_next_set_i,
  input  logic [WAYW-1:0] upd_next_way_i,
  output logic            fetch_vld_o,
  output logic [IDXW-1:0] fetch_set_o,
  output logic [WAYW-1:0] fetch_way_o,
  output logic [IDXW-1:0] pred_set_o,
  output logic [WAYW-1:0] pred_way_o,
  output logic [CNTW-1:0] miss_count_o
);
  logic [IDXW-1:0] cur_set;
  logic [WAYW-1:0] cur_way;
  logic [IDXW-1:0] nxt_set;
  logic [WAYW-1:0] nxt_way;

  lwp_table #(
    .SETS(SETS), .WAYS(WAYS), .IDXW(IDXW), .WAYW(WAYW)
  ) u_table (
    .clk            (clk),
    .rst_n          (rst_n),
    .fill_i         (fill_i),
    .fill_set_i     (fill_set_i),
    .fill_way_i     (fill_way_i),
    .upd_i          (upd_i),
    .upd_set_i      (upd_set_i),
    .upd_way_i      (upd_way_i),
    .upd_next_set_i (upd_next_set_i),
    .upd_next_way_i (upd_next_way_i),
    .rd_set_i       (cur_set),
    .rd_way_i       (cur_way),
    .rd_next_set_o  (nxt_set),
    .rd_next_way_o  (nxt_way)
  );

  lwp_fetch_ptr #(
    .IDXW(IDXW), .WAYW(WAYW)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (fetch_en_i),
    .redirect_i (redirect_i),
    .tgt_set_i  (redirect_set_i),
    .tgt_way_i  (redirect_way_i),
    .pred_set_i (nxt_set),
    .pred_way_i (nxt_way),
    .vld_o      (fetch_vld_o),
    .set_o      (cur_set),
    .way_o      (cur_way)
  );

  lwp_miss_counter #(
    .CNTW(CNTW)
  ) u_miss (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (redirect_i),
    .count_o (miss_count_o)
  );

  assign fetch_set_o = cur_set;
  assign fetch_way_o = cur_way;
  assign pred_set_o  = nxt_set;
  assign pred_way_o  = nxt_way;
endmodule

// File: rtl/lwp_checker.sv
module lwp_checker #(
  parameter int SETS = 16,
  parameter int WAYS = 2,
  parameter int CNTW = 8,
  localparam int IDXW = $clog2(SETS),
  localparam int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_en_i,
  input logic            redirect_i,
  input logic [IDXW-1:0] redirect_set_i,
  input logic [WAYW-1:0] redirect_way_i,
  input logic            fill_i,
  input logic [IDXW-1:0] fill_set_i,
  input logic [WAYW-1:0] fill_way_i,
  input logic            upd_i,
  input logic [IDXW-1:0] upd_set_i,
  input logic [WAYW-1:0] upd_way_i,
  input logic [IDXW-1:0] upd_next_set_i,
  input logic [WAYW-1:0] upd_next_way_i,
  input logic            fetch_vld_o,
  input logic [IDXW-1:0] fetch_set_o,
  input logic [WAYW-1:0] fetch_way_o,
  input logic [IDXW-1:0] pred_set_o,
  input logic [WAYW-1:0] pred_way_o,
  input logic [CNTW-1:0] miss_count_o
);
  logic [IDXW-1:0] fill_seq;
  logic            fill_on_tgt;
  logic            upd_on_tgt;
  logic            same_entry;

  always_comb begin
    fill_seq    = (fill_set_i == IDXW'(SETS - 1)) ? '0 : fill_set_i + 1'b1;
    fill_on_tgt = fill_i && redirect_i && (fill_set_i == redirect_set_i) && (fill_way_i == redirect_way_i);
    upd_on_tgt  = upd_i && redirect_i && (upd_set_i == redirect_set_i) && (upd_way_i == redirect_way_i);
    same_entry  = fill_i && upd_i && (fill_set_i == upd_set_i) && (fill_way_i == upd_way_i);
  end

  a_r3_follow_prediction: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld_o && fetch_en_i && !redirect_i) |=>
      (fetch_vld_o && fetch_set_o == $past(pred_set_o) && fetch_way_o == $past(pred_way_o)));

  a_r4_fill_seeds_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    fill_on_tgt |=> (pred_set_o == $past(fill_seq) && pred_way_o == '0));

  a_r5_update_written: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_on_tgt && !same_entry) |=>
      (pred_set_o == $past(upd_next_set_i) && pred_way_o == $past(upd_next_way_i)));

  a_r7_redirect_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> (!fetch_vld_o && fetch_set_o == $past(redirect_set_i) && fetch_way_o == $past(redirect_way_i)));

  a_r7_single_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_vld_o && fetch_en_i && !redirect_i) |=>
      (fetch_vld_o && $stable(fetch_set_o) && $stable(fetch_way_o)));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_en_i && !redirect_i) |=>
      ($stable(fetch_vld_o) && $stable(fetch_set_o) && $stable(fetch_way_o)));

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_i && miss_count_o != '1) |=> (miss_count_o == CNTW'($past(miss_count_o) + 1'b1)));

  a_r9_count_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_i && miss_count_o == '1) |=> (miss_count_o == '1));

  a_r9_count_still: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_i |=> $stable(miss_count_o));
endmodule

bind line_way_predictor lwp_checker #(.SETS(SETS), .WAYS(WAYS), .CNTW(CNTW)) u_lwp_checker (.*);

// File: tb/tb_line_way_predictor.sv
module tb_line_way_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 16;
  localparam int WAYS = 2;
  localparam int CNTW = 8;
  localparam int IDXW = $clog2(SETS);
  localparam int WAYW = 1;
  localparam int CMAX = (1 << CNTW) - 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            fetch_en_i, redirect_i, fill_i, upd_i;
  logic [IDXW-1:0] redirect_set_i, fill_set_i, upd_set_i, upd_next_set_i;
  logic [WAYW-1:0] redirect_way_i, fill_way_i, upd_way_i, upd_next_way_i;
  logic            fetch_vld_o;
  logic [IDXW-1:0] fetch_set_o, pred_set_o;
  logic [WAYW-1:0] fetch_way_o, pred_way_o;
  logic [CNTW-1:0] miss_count_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_way_predictor #(.SETS(SETS), .WAYS(WAYS), .CNTW(CNTW)) dut (.*);

  int n_checks = 0;
  int n_errors = 0;
  int m_set [SETS][WAYS];
  int m_way [SETS][WAYS];
  int m_ps, m_pw, m_vld, m_cnt;

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R3", "fetch valid", fetch_vld_o, m_vld);
    check("R3", "fetch set", fetch_set_o, m_ps);
    check("R3", "fetch way", fetch_way_o, m_pw);
    check("R2", "pred set", pred_set_o, m_set[m_ps][m_pw]);
    check("R2", "pred way", pred_way_o, m_way[m_ps][m_pw]);
    check("R9", "miss count", miss_count_o, m_cnt);
  endtask

  task automatic clear_ctrl();
    fetch_en_i = 1'b1; redirect_i = 1'b0; fill_i = 1'b0; upd_i = 1'b0;
    redirect_set_i = '0; redirect_way_i = '0; fill_set_i = '0; fill_way_i = '0;
    upd_set_i = '0; upd_way_i = '0; upd_next_set_i = '0; upd_next_way_i = '0;
  endtask

  // One clock: reference model updates from the inputs driven before the edge
  task automatic step();
    int ps, pw;
    @(posedge clk);
    ps = m_set[m_ps][m_pw];
    pw = m_way[m_ps][m_pw];
    if (redirect_i) begin
      m_ps = int'(redirect_set_i); m_pw = int'(redirect_way_i); m_vld = 0;
    end else if (fetch_en_i) begin
      if (m_vld == 1) begin m_ps = ps; m_pw = pw; end
      m_vld = 1;
    end
    if (upd_i) begin
      m_set[upd_set_i][upd_way_i] = int'(upd_next_set_i);
      m_way[upd_set_i][upd_way_i] = int'(upd_next_way_i);
    end
    if (fill_i) begin
      m_set[fill_set_i][fill_way_i] = (int'(fill_set_i) + 1) % SETS;
      m_way[fill_set_i][fill_way_i] = 0;
    end
    if (redirect_i && m_cnt < CMAX) m_cnt++;
    @(negedge clk);
    compare_all();
    clear_ctrl();
  endtask

  task automatic redirect_to(int s, int w, bit en);
    redirect_i = 1'b1; redirect_set_i = IDXW'(s); redirect_way_i = WAYW'(w); fetch_en_i = en;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clear_ctrl();
    fetch_en_i = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_set[s][w] = (s + 1) % SETS; m_way[s][w] = 0;
      end
    m_ps = 0; m_pw = 0; m_vld = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", "valid after reset", fetch_vld_o, 0);
    check("R1", "set after reset", fetch_set_o, 0);
    check("R1", "count after reset", miss_count_o, 0);
    check("R1", "seed pred set", pred_set_o, 1);
    check("R1", "seed pred way", pred_way_o, 0);
    fetch_en_i = 1'b1;

    // R3: sequential walk through seeded entries
    step(); step(); step();
    check("R3", "walk set", fetch_set_o, 2);
    check("R3", "walk valid", fetch_vld_o, 1);

    // R5 and R7: update then redirect to it
    upd_i = 1'b1; upd_set_i = 4'd3; upd_way_i = 1'b0; upd_next_set_i = 4'd12; upd_next_way_i = 1'b1;
    step();
    redirect_to(3, 0, 1'b1);
    check("R7", "bubble valid", fetch_vld_o, 0);
    check("R7", "bubble set", fetch_set_o, 3);
    check("R5", "updated pred set", pred_set_o, 12);
    check("R5", "updated pred way", pred_way_o, 1);
    step();
    check("R7", "after bubble valid", fetch_vld_o, 1);
    check("R7", "after bubble set", fetch_set_o, 3);
    step();
    check("R3", "follow updated set", fetch_set_o, 12);
    check("R3", "follow updated way", fetch_way_o, 1);

    // R4: fill reseeds an updated entry
    upd_i = 1'b1; upd_set_i = 4'd5; upd_way_i = 1'b1; upd_next_set_i = 4'd9; upd_next_way_i = 1'b1;
    step();
    fill_i = 1'b1; fill_set_i = 4'd5; fill_way_i = 1'b1;
    step();
    redirect_to(5, 1, 1'b1);
    check("R4", "fill pred set", pred_set_o, 6);
    check("R4", "fill pred way", pred_way_o, 0);

    // R6: fill and update collide, fill wins; last set wraps to 0
    fill_i = 1'b1; fill_set_i = 4'd15; fill_way_i = 1'b1;
    upd_i = 1'b1; upd_set_i = 4'd15; upd_way_i = 1'b1; upd_next_set_i = 4'd2; upd_next_way_i = 1'b1;
    step();
    redirect_to(15, 1, 1'b1);
    check("R6", "collision pred set", pred_set_o, 0);
    check("R6", "collision pred way", pred_way_o, 0);
    // R6: different entries both written
    fill_i = 1'b1; fill_set_i = 4'd7; fill_way_i = 1'b0;
    upd_i = 1'b1; upd_set_i = 4'd8; upd_way_i = 1'b0; upd_next_set_i = 4'd4; upd_next_way_i = 1'b1;
    step();
    redirect_to(8, 0, 1'b1);
    check("R6", "second write pred set", pred_set_o, 4);

    // R8: hold with fetch disabled, redirect still acts
    step(); step();
    fetch_en_i = 1'b0; step();
    fetch_en_i = 1'b0; step();
    check("R8", "hold set", fetch_set_o, 4);
    check("R8", "hold valid", fetch_vld_o, 1);
    redirect_to(10, 1, 1'b0);
    check("R7", "redirect while idle set", fetch_set_o, 10);
    fetch_en_i = 1'b0; step();
    check("R8", "bubble held while idle", fetch_vld_o, 0);
    step();
    check("R7", "bubble released", fetch_vld_o, 1);

    // R9: saturation
    for (int i = 0; i < CMAX + 5; i++) redirect_to(i % SETS, i % WAYS, 1'b1);
    check("R9", "saturated count", miss_count_o, CMAX);

    // Mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      fetch_en_i     = ($urandom_range(0, 4) != 0);
      redirect_i     = ($urandom_range(0, 7) == 0);
      redirect_set_i = IDXW'($urandom_range(0, SETS-1));
      redirect_way_i = WAYW'($urandom_range(0, WAYS-1));
      fill_i         = ($urandom_range(0, 3) == 0);
      fill_set_i     = IDXW'($urandom_range(0, SETS-1));
      fill_way_i     = WAYW'($urandom_range(0, WAYS-1));
      upd_i          = ($urandom_range(0, 2) == 0);
      upd_set_i      = IDXW'($urandom_range(0, SETS-1));
      upd_way_i      = WAYW'($urandom_range(0, WAYS-1));
      upd_next_set_i = IDXW'($urandom_range(0, SETS-1));
      upd_next_way_i = WAYW'($urandom_range(0, WAYS-1));
      step();
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule